// File: doc/BRIEF.md
# Card-Presence Debounce Filter

This block cleans up the raw contact that reports whether a card sits in its holder. The raw level is first brought into the reference clock domain, then a new level is taken as valid only once it has held without a break for a programmed time. The time base depends on the direction of the change. A removal is timed in short units so the contacts can be released quickly. An insertion is timed in units eight times longer, so a card is not powered while it is still sliding into place.

Every accepted change raises a sticky event flag. A status read clears the flag, and a mask bit decides whether the flag drives the interrupt line. On an accepted removal a one-cycle pulse tells the contact sequencer to deactivate the card. This block does not drive the contacts.

Top module: `cd_debounce`

## Requirements
- R1: The raw input passes through two synchroniser flops. With a delay setting of 0, `present_o` takes a new raw level on the third rising clock edge after the raw change.
- R2: An insertion (filtered level 0 to 1) is accepted only after the synchronised input has differed from `present_o` on `dly_sel_i * INS_UNIT` consecutive edges. It is accepted on the next edge after those.
- R3: An extraction (1 to 0) follows the same rule as R2, with `EXT_UNIT` in place of `INS_UNIT`.
- R4: If the synchronised input returns to the accepted level before acceptance, the count restarts from zero.
- R5: After reset `present_o` is 0 (no card) and the flag, interrupt and pulse outputs are 0. `present_o` = 1 means a card is detected.
- R6: An accepted change sets `cd_flag_o` in the same cycle that `present_o` changes. A `stat_rd_i` strobe with no new event clears it on the next edge.
- R7: When an accepted change and `stat_rd_i` fall on the same edge, the flag is left set.
- R8: `cd_irq_o` is `cd_flag_o` gated by `irq_mask_i`: mask = 1 holds the interrupt low but still lets the flag set.
- R9: `extract_o` is high for exactly the one cycle in which `present_o` falls. It never pulses on an insertion.
- R10: A delay setting of 0 gives the shortest path: the change is accepted on the first edge at which the synchronised level differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_cd_i | input | 1 | Unsynchronised card-detect contact, 1 = card |
| dly_sel_i | input | 4 | Filter length in time units |
| irq_mask_i | input | 1 | 1 = suppress the interrupt line |
| stat_rd_i | input | 1 | Status-read strobe, clears the event flag |
| present_o | output | 1 | Filtered presence, 1 = card detected |
| cd_flag_o | output | 1 | Sticky insertion/extraction event flag |
| cd_irq_o | output | 1 | Masked event interrupt |
| extract_o | output | 1 | One-cycle pulse on accepted extraction |

## Verification
A raw edge reaches `present_o` on edge `3 + dly_sel_i * unit`, where the unit follows the direction of the change. The flag and the removal pulse change on that same edge, and a clearing read takes effect one edge after the strobe. The bench drives inputs 2 ns after a rising edge and samples on the falling edge. A behavioural model counts consecutive differing samples and is compared with every output on every clock. Directed checks also sample `present_o` one edge before and on the exact edge of acceptance, so that an off-by-one in either direction is reported.

// File: rtl/cd_deb_pkg.sv
package cd_deb_pkg;
  localparam int DLY_W = 4;

  typedef struct packed {
    logic hit;  // change accepted this cycle
    logic lvl;  // level being accepted
  } cd_evt_t;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cd_filter.sv
module cd_filter
  import cd_deb_pkg::*;
#(
  parameter int EXT_UNIT = 1024,
  parameter int INS_UNIT = 8192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pres_o,
  output cd_evt_t          evt_o
);
  localparam int MAX_UNIT = (INS_UNIT > EXT_UNIT) ? INS_UNIT : EXT_UNIT;
  localparam int CYC_W    = (MAX_UNIT > 2) ? $clog2(MAX_UNIT) : 1;
  localparam logic [CYC_W-1:0] INS_LAST = CYC_W'(INS_UNIT - 1);
  localparam logic [CYC_W-1:0] EXT_LAST = CYC_W'(EXT_UNIT - 1);

  logic             pres_q;
  logic [CYC_W-1:0] cyc_q;
  logic [DLY_W-1:0] unit_q;
  logic             differ;
  logic             done;
  logic [CYC_W-1:0] unit_last;

  assign differ    = lvl_i ^ pres_q;
  assign done      = (unit_q >= dly_i);
  // direction picks the time base: moving to 1 is insertion
  assign unit_last = lvl_i ? INS_LAST : EXT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= 1'b0;
      cyc_q  <= '0;
      unit_q <= '0;
    end else if (!differ) begin
      cyc_q  <= '0;
      unit_q <= '0;
    end else if (done) begin
      pres_q <= lvl_i;
      cyc_q  <= '0;
      unit_q <= '0;
    end else if (cyc_q == unit_last) begin
      cyc_q  <= '0;
      unit_q <= unit_q + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign pres_o    = pres_q;
  assign evt_o.hit = differ & done;
  assign evt_o.lvl = lvl_i;
endmodule

// File: rtl/cd_flag.sv
module cd_flag
  import cd_deb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cd_evt_t evt_i,
  input  logic    rd_i,
  input  logic    mask_i,
  output logic    flag_o,
  output logic    irq_o,
  output logic    ext_o
);
  logic flag_q;
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      // a new event beats a concurrent read
      flag_q <= evt_i.hit | (flag_q & ~rd_i);
      ext_q  <= evt_i.hit & ~evt_i.lvl;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_i;
  assign ext_o  = ext_q;
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce
  import cd_deb_pkg::*;
#(
  parameter int EXT_UNIT    = 1024,
  parameter int INS_UNIT    = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_cd_i,
  input  logic [DLY_W-1:0] dly_sel_i,
  input  logic             irq_mask_i,
  input  logic             stat_rd_i,
  output logic             present_o,
  output logic             cd_flag_o,
  output logic             cd_irq_o,
  output logic             extract_o
);
  logic    sync_lvl;
  cd_evt_t evt;

  cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_cd_i),
    .q_o   (sync_lvl)
  );

  cd_filter #(.EXT_UNIT(EXT_UNIT), .INS_UNIT(INS_UNIT)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .dly_i (dly_sel_i),
    .pres_o(present_o),
    .evt_o (evt)
  );

  cd_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .rd_i  (stat_rd_i),
    .mask_i(irq_mask_i),
    .flag_o(cd_flag_o),
    .irq_o (cd_irq_o),
    .ext_o (extract_o)
  );
endmodule

// File: rtl/cd_debounce_chk.sv
module cd_debounce_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic raw_cd_i,
  input logic irq_mask_i,
  input logic stat_rd_i,
  input logic present_o,
  input logic cd_flag_o,
  input logic cd_irq_o,
  input logic extract_o
);
  p_sync_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o != $past(present_o)) |-> ($past(raw_cd_i, 2) == present_o));

  p_flag_on_change_r6_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o != $past(present_o)) |-> cd_flag_o);

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (!cd_flag_o || (present_o != $past(present_o))));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_irq_o |-> (cd_flag_o && !irq_mask_i));

  p_extract_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extract_o |-> (!present_o && $past(present_o)));

  p_extract_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extract_o |=> !extract_o);
endmodule

bind cd_debounce cd_debounce_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .raw_cd_i  (raw_cd_i),
  .irq_mask_i(irq_mask_i),
  .stat_rd_i (stat_rd_i),
  .present_o (present_o),
  .cd_flag_o (cd_flag_o),
  .cd_irq_o  (cd_irq_o),
  .extract_o (extract_o)
);

// File: tb/cd_debounce_tb.sv
`timescale 1ns/1ps
module cd_debounce_tb;
  localparam int EXT_U = 8;
  localparam int INS_U = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic [3:0] dly = 4'd0;
  logic       mask = 1'b0;
  logic       rd = 1'b0;
  logic       present, flag, irq, ext;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cd_debounce #(.EXT_UNIT(EXT_U), .INS_UNIT(INS_U)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .raw_cd_i  (raw),
    .dly_sel_i (dly),
    .irq_mask_i(mask),
    .stat_rd_i (rd),
    .present_o (present),
    .cd_flag_o (flag),
    .cd_irq_o  (irq),
    .extract_o (ext)
  );

  // behavioural reference: count consecutive differing samples
  logic m_s1, m_s2, m_pres, m_flag, m_ext;
  int   m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_pres <= 0; m_flag <= 0; m_ext <= 0; m_cnt <= 0;
    end else begin
      int unit;
      bit hit;
      unit = m_s2 ? INS_U : EXT_U;
      hit  = (m_s2 != m_pres) && (m_cnt >= int'(dly) * unit);
      m_s1 <= raw;
      m_s2 <= m_s1;
      if (m_s2 == m_pres || hit) m_cnt <= 0;
      else                       m_cnt <= m_cnt + 1;
      if (hit) m_pres <= m_s2;
      m_ext  <= hit && !m_s2;
      m_flag <= hit || (m_flag && !rd);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2/R3 present vs model", present, m_pres);
      chk("R6 flag vs model", flag, m_flag);
      chk("R8 irq vs model", irq, m_flag & ~mask);
      chk("R9 extract vs model", ext, m_ext);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R5 reset present", present, 0);
    chk("R5 reset flag", flag, 0);
    chk("R5 reset extract", ext, 0);
    rst_n = 1'b1;
    cyc(2);

    // R1/R10: zero delay, insertion lands on third edge
    raw = 1; cyc(2);
    chk("R1 not yet", present, 0);
    cyc(1);
    chk("R10 accepted", present, 1);
    chk("R6 flag set", flag, 1);
    chk("R9 no pulse on insertion", ext, 0);
    rd = 1; cyc(1); rd = 0;
    chk("R6 read clears", flag, 0);

    // R3: extraction, dly 2 -> edge 3+16
    dly = 2; raw = 0; cyc(18);
    chk("R3 held before", present, 1);
    cyc(1);
    chk("R3 accepted", present, 0);
    chk("R9 pulse", ext, 1);
    cyc(1);
    chk("R9 one cycle", ext, 0);
    rd = 1; cyc(1); rd = 0;

    // R2 with mask R8: insertion dly 2 -> edge 3+64
    mask = 1; raw = 1; cyc(66);
    chk("R2 held before", present, 0);
    cyc(1);
    chk("R2 accepted", present, 1);
    chk("R8 flag under mask", flag, 1);
    chk("R8 irq masked", irq, 0);
    mask = 0; #1;
    chk("R8 irq unmasked", irq, 1);
    rd = 1; cyc(1); rd = 0;

    // R4: bounce restarts count, dly 1
    dly = 1; raw = 0; cyc(5);
    raw = 1; cyc(1);
    raw = 0; cyc(6);
    chk("R4 no accept at unbounced time", present, 1);
    cyc(4);
    chk("R4 still counting", present, 1);
    cyc(1);
    chk("R4 accepted after restart", present, 0);
    rd = 1; cyc(1); rd = 0;
    chk("R6 cleared again", flag, 0);

    // R7: read on the accepting edge
    dly = 0; raw = 1; cyc(2);
    rd = 1; cyc(1); rd = 0;
    chk("R7 set wins", flag, 1);
    chk("R7 present", present, 1);
    cyc(4);
    finish_run();
  end
endmodule